// File: doc/BRIEF.md
# Real-Time Clock Register Front End

This block is the byte-wide register window of a real-time clock. It claims the eight highest addresses of a 15-bit address space and keeps a set of user-visible holding registers apart from the running time counters, which live in a separate block. Accesses use a synchronous chip select together with write and read strobes. Reads return one registered byte. Writes update the holding registers and a small set of control bits.

While both the halt-for-read bit and the halt-for-write bit are clear, the holding registers take a full snapshot of the counters on every one-second tick. The read bit freezes that snapshot so that software sees a consistent time while the counters keep running. The write bit also stops the snapshot so that software can load new values. When software clears the write bit, the block sends those holding values to the counters with a one-cycle load pulse. Three status and control bits are mixed into the readback: a battery-good flag, a frequency-test enable that routes a 512 Hz square wave onto the seconds LSB, and an oscillator-stop bit.

Top module: `rtc_regfront`

## Requirements
- R1: An address hits the clock window only when all of its bits above bit 2 are 1 (0x7FF8 to 0x7FFF). Address bits [2:0] select the byte: 0 century/control, 1 seconds, 2 minutes, 3 hours, 4 day/flags, 5 date, 6 month, 7 year. `hit_o` shows the hit combinationally.
- R2: Outside the window, and in any cycle without a clock read, `rdata_o` is 0 in the following cycle. A write outside the window changes no clock byte.
- R3: A read strobe with `cs_i` on a hit presents the selected byte on `rdata_o` one cycle later.
- R4: When the read and write bits are both clear and no load pulse is active, a `tick_1s_i` cycle copies all eight counter bytes from `cnt_snap_i` (byte i at bits [8i+7:8i]) into the holding registers in that one edge. A write to the same byte in that cycle takes precedence.
- R5: Century bit 6 is the read bit. While it is 1, ticks leave the holding registers unchanged. After it is cleared, the next tick refreshes every byte together.
- R6: Century bit 7 is the write bit. While it is 1, ticks are ignored, and writes to the time bytes land in the holding registers and read back unchanged.
- R7: A century write with bit 7 = 0 while the write bit is 1 raises `cnt_load_o` for exactly the next cycle. During that cycle, `cnt_load_val_o` carries the holding bytes in the R4 layout, including the century value from that same write.
- R8: Day bit 7 reads the `batt_ok_i` input, and writes do not change it.
- R9: Day bit 6 is the frequency-test enable, shown on `ftest_o`. While it is 1 and the oscillator is not stopped, the seconds byte reads its LSB from `sq512_i`.
- R10: Seconds bit 7 is the oscillator-stop bit. It drives `osc_halt_o` and reads back in place.
- R11: Bits that hold no value are stored as 0 and read as 0, both on writes and on snapshots. The stored masks are: century 0x3F, seconds 0x7F, minutes 0x7F, hours 0x3F, day 0x07, date 0x3F, month 0x1F, year 0xFF.
- R12: After reset, all holding bytes and control bits are 0 and `rdata_o` and `cnt_load_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 15 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data, 0 when not reading the window |
| hit_o | output | 1 | Address lies in the clock window |
| tick_1s_i | input | 1 | One-cycle pulse per second from the counters |
| sq512_i | input | 1 | 512 Hz square wave |
| batt_ok_i | input | 1 | Battery good |
| cnt_snap_i | input | 64 | Current counter bytes |
| cnt_load_o | output | 1 | Load pulse to the counters |
| cnt_load_val_o | output | 64 | Values to load into the counters |
| osc_halt_o | output | 1 | Oscillator stop request |
| ftest_o | output | 1 | Frequency test enable |

## Verification
The hardest case to reach is a frozen window that drifts away from the counters. The counters must change while the read or write bit is held, a tick must arrive in that window, and the bit must then be released. Only the tick after the release may show the new time. The stimulus reaches this by modelling the counters in the bench and changing them at random between ticks. Random century writes set and clear both halt bits. Each load pulse is also fed back into the bench's counters, so a later snapshot shows whether the transfer carried the right bytes.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int DATA_W = 8;
    localparam int NREG   = 8;
    localparam int IDX_W  = $clog2(NREG);
    localparam int BUS_W  = NREG * DATA_W;

    typedef enum logic [IDX_W-1:0] {
        IX_CENT = 3'd0,
        IX_SEC  = 3'd1,
        IX_MIN  = 3'd2,
        IX_HOUR = 3'd3,
        IX_DAY  = 3'd4,
        IX_DATE = 3'd5,
        IX_MON  = 3'd6,
        IX_YEAR = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic wr_halt;
        logic rd_halt;
        logic osc_stop;
        logic ftest;
    } ctrl_t;

    typedef struct packed {
        logic                req;
        logic                wr;
        reg_idx_e            idx;
        logic [DATA_W-1:0]   data;
    } bus_req_t;

    function automatic logic [DATA_W-1:0] field_mask(input reg_idx_e i);
        case (i)
            IX_CENT: return 8'h3F;
            IX_SEC:  return 8'h7F;
            IX_MIN:  return 8'h7F;
            IX_HOUR: return 8'h3F;
            IX_DAY:  return 8'h07;
            IX_DATE: return 8'h3F;
            IX_MON:  return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] all_masks();
        logic [BUS_W-1:0] m;
        for (int k = 0; k < NREG; k++)
            m[k*DATA_W +: DATA_W] = field_mask(reg_idx_e'(k));
        return m;
    endfunction
endpackage

// File: rtl/rtc_decode.sv
module rtc_decode
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              cs,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              hit,
    output logic              rd_req,
    output bus_req_t          rq
);
    localparam int HI_W = ADDR_W - IDX_W;

    always_comb begin
        hit     = &addr[ADDR_W-1:IDX_W];
        rq.req  = cs && hit && (wr || rd);
        rq.wr   = wr;
        rq.idx  = reg_idx_e'(addr[IDX_W-1:0]);
        rq.data = wdata;
        rd_req  = cs && hit && rd && !wr;
    end

    initial begin
        assert (HI_W >= 1) else $error("address too narrow for clock window");
    end
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
    import rtc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t rq,
    output ctrl_t    ctl,
    output logic     load_p
);
    logic wr_en;
    assign wr_en = rq.req && rq.wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl    <= '0;
            load_p <= 1'b0;
        end else begin
            load_p <= 1'b0;
            if (wr_en) begin
                case (rq.idx)
                    IX_CENT: begin
                        ctl.wr_halt <= rq.data[7];
                        ctl.rd_halt <= rq.data[6];
                        load_p      <= ctl.wr_halt && !rq.data[7];
                    end
                    IX_SEC:  ctl.osc_stop <= rq.data[7];
                    IX_DAY:  ctl.ftest    <= rq.data[6];
                    default: ;
                endcase
            end
        end
    end

    // R7: a load pulse only follows the write bit falling
    assert_load_on_release_R7: assert property (@(posedge clk) disable iff (rst)
        load_p |-> ($past(ctl.wr_halt) && !ctl.wr_halt));

    // R7: the load pulse lasts a single cycle
    assert_load_single_R7: assert property (@(posedge clk) disable iff (rst)
        load_p |=> !load_p);
endmodule

// File: rtl/rtc_hold.sv
module rtc_hold
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         rq,
    input  logic             tick,
    input  logic             freeze,
    input  logic             load_p,
    input  logic [BUS_W-1:0] snap,
    output logic [BUS_W-1:0] hold
);
    localparam logic [BUS_W-1:0] MASKS = all_masks();

    logic copy_en;
    logic wr_en;
    assign copy_en = tick && !freeze && !load_p;
    assign wr_en   = rq.req && rq.wr;

    for (genvar i = 0; i < NREG; i++) begin : g_fld
        localparam logic [DATA_W-1:0] M = field_mask(reg_idx_e'(i));
        always_ff @(posedge clk) begin
            if (rst)
                hold[i*DATA_W +: DATA_W] <= '0;
            else if (wr_en && rq.idx == reg_idx_e'(i))
                hold[i*DATA_W +: DATA_W] <= rq.data & M;
            else if (copy_en)
                hold[i*DATA_W +: DATA_W] <= snap[i*DATA_W +: DATA_W] & M;
        end
    end

    // R5/R6: while halted and not written, the holding bytes do not move
    assert_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        (freeze && !wr_en) |=> $stable(hold));

    // R4: an uncontested tick captures the whole masked snapshot
    assert_snapshot_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && !freeze && !load_p && !wr_en) |=> hold == ($past(snap) & MASKS));
endmodule

// File: rtl/rtc_rdmux.sv
module rtc_rdmux
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  reg_idx_e          idx,
    input  logic [BUS_W-1:0]  hold,
    input  ctrl_t             ctl,
    input  logic              batt_ok,
    input  logic              sq512,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] byte_sel;
    logic [DATA_W-1:0] fld;
    logic              sec_lsb;

    always_comb begin
        fld     = hold[idx*DATA_W +: DATA_W];
        sec_lsb = (ctl.ftest && !ctl.osc_stop) ? sq512 : fld[0];
        case (idx)
            IX_CENT: byte_sel = {ctl.wr_halt, ctl.rd_halt, fld[5:0]};
            IX_SEC:  byte_sel = {ctl.osc_stop, fld[6:1], sec_lsb};
            IX_DAY:  byte_sel = {batt_ok, ctl.ftest, 3'b000, fld[2:0]};
            default: byte_sel = fld;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata <= '0;
        else if (rd_req) rdata <= byte_sel;
        else             rdata <= '0;
    end
endmodule

// File: rtl/rtc_regfront.sv
module rtc_regfront
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    output logic              hit_o,
    input  logic              tick_1s_i,
    input  logic              sq512_i,
    input  logic              batt_ok_i,
    input  logic [63:0]       cnt_snap_i,
    output logic              cnt_load_o,
    output logic [63:0]       cnt_load_val_o,
    output logic              osc_halt_o,
    output logic              ftest_o
);
    bus_req_t         rq;
    ctrl_t            ctl;
    logic             rd_req;
    logic             load_p;
    logic [BUS_W-1:0] hold;

    rtc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .cs(cs_i), .wr(wr_i), .rd(rd_i), .addr(addr_i), .wdata(wdata_i),
        .hit(hit_o), .rd_req(rd_req), .rq(rq)
    );

    rtc_ctrl u_ctrl (
        .clk(clk), .rst(rst), .rq(rq), .ctl(ctl), .load_p(load_p)
    );

    rtc_hold u_hold (
        .clk(clk), .rst(rst), .rq(rq), .tick(tick_1s_i),
        .freeze(ctl.wr_halt || ctl.rd_halt), .load_p(load_p),
        .snap(cnt_snap_i), .hold(hold)
    );

    rtc_rdmux u_rd (
        .clk(clk), .rst(rst), .rd_req(rd_req), .idx(rq.idx), .hold(hold),
        .ctl(ctl), .batt_ok(batt_ok_i), .sq512(sq512_i), .rdata(rdata_o)
    );

    assign cnt_load_o     = load_p;
    assign cnt_load_val_o = hold;
    assign osc_halt_o     = ctl.osc_stop;
    assign ftest_o        = ctl.ftest;

    // R2: no clock read means a zero data bus next cycle
    assert_miss_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !(cs_i && rd_i && !wr_i && hit_o) |=> rdata_o == 8'h00);

    // R8: the battery flag follows the input, not the stored byte
    assert_batt_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (cs_i && rd_i && !wr_i && hit_o && addr_i[2:0] == 3'd4)
        |=> rdata_o[7] == $past(batt_ok_i));
endmodule

// File: tb/sim_rtc_regfront.sv
module sim_rtc_regfront;
    logic        clk = 1'b0;
    logic        rst;
    logic        cs, wr, rd;
    logic [14:0] addr;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic        hit;
    logic        tick, sq, batt;
    logic [63:0] snap;
    logic        ld;
    logic [63:0] ld_val;
    logic        osc_h, ft_o;

    always #10 clk = ~clk;

    rtc_regfront u0 (
        .clk(clk), .rst(rst), .cs_i(cs), .wr_i(wr), .rd_i(rd), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .hit_o(hit), .tick_1s_i(tick),
        .sq512_i(sq), .batt_ok_i(batt), .cnt_snap_i(snap), .cnt_load_o(ld),
        .cnt_load_val_o(ld_val), .osc_halt_o(osc_h), .ftest_o(ft_o)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [7:0] m_hold [8];
    logic [7:0] cnt [8];
    bit m_wb, m_rb, m_osc, m_ft;

    always_comb for (int i = 0; i < 8; i++) snap[i*8 +: 8] = cnt[i];

    function automatic logic [7:0] bmask(int i);
        case (i)
            0: return 8'h3F; 1: return 8'h7F; 2: return 8'h7F; 3: return 8'h3F;
            4: return 8'h07; 5: return 8'h3F; 6: return 8'h1F; default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] exp_byte(int i);
        case (i)
            0: return {m_wb, m_rb, m_hold[0][5:0]};
            1: return {m_osc, m_hold[1][6:1], (m_ft && !m_osc) ? sq : m_hold[1][0]};
            4: return {batt, m_ft, 3'b000, m_hold[4][2:0]};
            default: return m_hold[i];
        endcase
    endfunction

    function automatic logic [63:0] model_flat();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[i*8 +: 8] = m_hold[i];
        return v;
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(logic [14:0] a, logic [7:0] d);
        bit h, exp_ld;
        int ix;
        h = (a[14:3] == 12'hFFF);
        ix = a[2:0];
        cs = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk);
        cs = 0; wr = 0;
        exp_ld = h && ix == 0 && m_wb && !d[7];
        if (h) begin
            m_hold[ix] = d & bmask(ix);
            if (ix == 0) begin m_wb = d[7]; m_rb = d[6]; end
            if (ix == 1) m_osc = d[7];
            if (ix == 4) m_ft = d[6];
        end
        check(ld == exp_ld, "R7 load pulse", ld, exp_ld);
        check(osc_h == m_osc && ft_o == m_ft, "R10/R9 control outputs",
              {osc_h, ft_o}, {m_osc, m_ft});
        if (exp_ld) begin
            check(ld_val == model_flat(), "R7 load value", ld_val, model_flat());
            for (int i = 0; i < 8; i++) cnt[i] = ld_val[i*8 +: 8];
        end
        @(negedge clk);
        check(ld == 1'b0, "R7 pulse width", ld, 0);
    endtask

    task automatic do_read(logic [14:0] a, string req);
        bit h;
        logic [7:0] e;
        h = (a[14:3] == 12'hFFF);
        cs = 1; rd = 1; addr = a;
        #1;
        check(hit == h, "R1 hit decode", hit, h);
        e = h ? exp_byte(a[2:0]) : 8'h00;
        @(negedge clk);
        cs = 0; rd = 0;
        check(rdata == e, req, rdata, e);
    endtask

    task automatic do_tick();
        tick = 1;
        @(negedge clk);
        tick = 0;
        if (!m_wb && !m_rb)
            for (int i = 0; i < 8; i++) m_hold[i] = cnt[i] & bmask(i);
    endtask

    task automatic rand_cnt();
        for (int i = 0; i < 8; i++) cnt[i] = 8'($urandom);
    endtask

    task automatic read_all(string req);
        for (int i = 0; i < 8; i++) do_read(15'h7FF8 + 15'(i), req);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h1234);
        rst = 1; cs = 0; wr = 0; rd = 0; addr = 0; wdata = 0;
        tick = 0; sq = 0; batt = 1;
        for (int i = 0; i < 8; i++) begin cnt[i] = 0; m_hold[i] = 0; end
        m_wb = 0; m_rb = 0; m_osc = 0; m_ft = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(rdata == 0 && ld == 0 && osc_h == 0 && ft_o == 0, "R12 reset outputs",
              {rdata, ld, osc_h, ft_o}, 0);
        read_all("R12 reset bytes");

        // R4/R11: full snapshot with unused bits stripped
        for (int i = 0; i < 8; i++) cnt[i] = 8'hFF - 8'(i);
        do_tick();
        read_all("R4 R11 snapshot");

        // R5: freeze, counters move, tick ignored, release then refresh
        do_write(15'h7FF8, 8'h40);
        rand_cnt();
        do_tick();
        read_all("R5 frozen");
        do_write(15'h7FF8, 8'h00);
        read_all("R5 still old before tick");
        do_tick();
        read_all("R5 refreshed");

        // R6/R7: load via write bit
        do_write(15'h7FF8, 8'h80);
        do_write(15'h7FF9, 8'h45);
        do_write(15'h7FFA, 8'h59);
        do_write(15'h7FFF, 8'h99);
        rand_cnt();
        do_tick();
        read_all("R6 held values");
        do_write(15'h7FF8, 8'h20);
        read_all("R7 after transfer");
        do_tick();
        read_all("R7 counters loaded");

        // R8: battery flag unwritable
        batt = 0;
        do_write(15'h7FFC, 8'h80);
        do_read(15'h7FFC, "R8 battery low");
        batt = 1;
        do_read(15'h7FFC, "R8 battery good");

        // R9/R10: frequency test and oscillator stop
        do_write(15'h7FFC, 8'h40);
        sq = 1; do_read(15'h7FF9, "R9 sq high");
        sq = 0; do_read(15'h7FF9, "R9 sq low");
        do_write(15'h7FF9, 8'h80);
        sq = 1; do_read(15'h7FF9, "R10 stop masks test");
        do_write(15'h7FF9, 8'h00);
        do_write(15'h7FFC, 8'h00);

        // R2: outside the window
        do_write(15'h3FFF, 8'h12);
        do_write(15'h7FF7, 8'h34);
        do_read(15'h7FF7, "R2 out of range read");
        do_read(15'h0000, "R2 low address read");
        read_all("R2 window untouched");

        // random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            logic [14:0] a;
            op = $urandom_range(0, 9);
            a = ($urandom_range(0, 9) < 7) ? (15'h7FF8 | 15'($urandom_range(0, 7)))
                                           : 15'($urandom);
            case (op)
                0, 1, 2: do_write(a, 8'($urandom));
                3, 4, 5: do_read(a, "R3 random read");
                6, 7:    do_tick();
                8:       rand_cnt();
                default: begin sq = 1'($urandom); batt = 1'($urandom); end
            endcase
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule